// File: doc/BRIEF.md
# Serial Flash Transaction Phase Sequencer

This block is the master-side controller for one serial-flash transaction at a time. Software loads a set of configuration registers: per-phase enables, per-phase lengths, a command word, an address and flags. It then sets a start bit. The sequencer asserts chip select and walks through the enabled phases in a fixed order: command, address, dummy, write data, read data. It shifts bits out on a single output line and samples a single input line.

Write data is taken from a buffer of 32-bit words. Read data is stored back into that same buffer. The current state is visible on a 4-bit status output. A one-cycle end event marks the return to idle.

Shifting advances only on cycles where the external shift-clock enable is high, so the serial bit rate is set outside the block. A synchronous clear input aborts any transaction at once.

Top module: `sflash_seq`

## Requirements
- R1: After reset the state output is 0 and cs_n is 1. Register 0 reads 0x00007002 (only the command phase is enabled, and the command length field is 7). Register 2 reads 0x00000717 (address length field 23, dummy length field 7). Register 3 reads 0.
- R2: The state output uses this encoding: 0 idle, 1 prepare, 2 command, 3 address, 4 dummy, 5 read data, 6 write data, 7 done, 8 read-data end.
  - A start leads from idle to prepare.
  - The enabled phases follow in the order command, address, dummy, write, read, and disabled phases are skipped.
  - A read phase is followed by read-data end, then done. Done leads back to idle.
- R3: Each phase lasts (length field + 1) shift-clock-enable cycles. The state and bit position hold while the enable is low.
- R4: Command bits go out most significant first, starting at bit cmd_len of the command value. Address bits go out starting at bit addr_len of the address.
- R5: Data bit k of a write or read phase maps to buffer word k/32, bit k%32. Write data is sent from that position, and each read bit sampled on miso is stored there.
- R6: With the write-upper flag (register 0 bit 6) or the read-upper flag (bit 7) set, that phase addresses word 8 + (k/32)%8, so words 0 to 7 are untouched.
- R7: Register 0 bit 0 sets the start bit. It reads 1 while a transaction runs and clears itself when the machine returns to idle.
- R8: sck_on is 1 in the command, address, write and read phases. In the dummy phase it is 1 unless the dummy-idle flag (register 0 bit 8) is set, in which case it is 0 for the whole phase.
- R9: cs_n is 0 in every non-idle state. end_o is high for exactly one cycle: the first idle cycle after a non-idle state, when cs_n is already 1.
- R10: With the keep-active flag (register 0 bit 9) set, cs_n stays 0 in idle too.
- R11: A high sync_clr returns the machine to idle on the next edge, raises cs_n and clears the start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous abort to idle |
| sclk_en | input | 1 | Shift-clock enable; one bit per high cycle |
| reg_we | input | 1 | Configuration register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 address, 2 address/dummy lengths, 3 data lengths |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back of the register picked by reg_sel |
| buf_we | input | 1 | Buffer word write strobe |
| buf_idx | input | 4 | Buffer word index |
| buf_wdata | input | 32 | Buffer write data |
| buf_rdata | output | 32 | Buffer word at buf_idx |
| cs_n | output | 1 | Chip select, active low |
| sck_on | output | 1 | Serial clock gate for the pad clock generator |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| state_o | output | 4 | Current state code |
| end_o | output | 1 | One-cycle end-of-transaction event |

## Verification
A start write is followed by prepare two edges later. With the enable held high, every later phase state then lasts exactly its length plus one cycles. Each serial output bit is valid during the cycle its phase state is shown, and a miso bit driven in a read-state cycle is captured at the following edge.

The bench samples every output at the falling edge. It attributes each bit to the state shown at that sample, which keeps the checks aligned with the edge-by-edge progress. The end event, chip-select release and start-bit clearing are all checked at the first idle sample. A synchronous clear is checked one sample after the edge that takes it.

// File: rtl/sflash_seq.sv
module sflash_seq #(
  parameter int BUF_WORDS = 16,
  parameter int WORD_W    = 32,
  parameter int DLEN_W    = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sync_clr,
  input  logic                         sclk_en,
  input  logic                         reg_we,
  input  logic [1:0]                   reg_sel,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  input  logic                         buf_we,
  input  logic [$clog2(BUF_WORDS)-1:0] buf_idx,
  input  logic [WORD_W-1:0]            buf_wdata,
  output logic [WORD_W-1:0]            buf_rdata,
  output logic                         cs_n,
  output logic                         sck_on,
  output logic                         mosi,
  input  logic                         miso,
  output logic [3:0]                   state_o,
  output logic                         end_o
);
  localparam int IDX_W = $clog2(BUF_WORDS);
  localparam int BIT_W = $clog2(WORD_W);

  typedef enum logic [3:0] {
    S_IDLE = 4'd0, S_PREP = 4'd1, S_CMD = 4'd2, S_ADDR = 4'd3, S_DUMMY = 4'd4,
    S_RD = 4'd5, S_WR = 4'd6, S_DONE = 4'd7, S_RDEND = 4'd8
  } st_t;

  st_t               state, nxt;
  logic [DLEN_W-1:0] cnt, cur_len;
  logic              start_q, prev_busy, fin, shifting, hi_sel;
  logic              en_cmd, en_addr, en_dum, en_wr, en_rd, wr_hi, rd_hi, didle, keep;
  logic [3:0]        cmd_len, ci;
  logic [15:0]       cmd_val;
  logic [31:0]       addr_q, len_rd, dlen_rd;
  logic [5:0]        addr_len, dum_len, ai;
  logic [DLEN_W-1:0] wr_len, rd_len;
  logic [4:0]        en_vec;
  logic [IDX_W-1:0]  widx;
  logic [BIT_W-1:0]  bidx;
  logic [WORD_W-1:0] mem [BUF_WORDS];
  int                from;

  assign fin      = (state == S_DONE && sclk_en) || sync_clr;
  assign shifting = state inside {S_CMD, S_ADDR, S_DUMMY, S_WR, S_RD};
  assign en_vec   = {en_rd, en_wr, en_dum, en_addr, en_cmd};
  assign hi_sel   = (state == S_RD) ? rd_hi : wr_hi;
  assign widx     = hi_sel ? {1'b1, cnt[BIT_W +: (IDX_W-1)]} : cnt[BIT_W +: IDX_W];
  assign bidx     = cnt[BIT_W-1:0];
  assign ci       = cmd_len - cnt[3:0];
  assign ai       = addr_len - cnt[5:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en_addr, en_dum, en_wr, en_rd, wr_hi, rd_hi, didle, keep} <= '0;
      en_cmd <= 1'b1; cmd_len <= 4'd7; cmd_val <= '0; addr_q <= '0;
      addr_len <= 6'd23; dum_len <= 6'd7; wr_len <= '0; rd_len <= '0;
      start_q <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_sel)
          2'd0: begin
            {keep, didle, rd_hi, wr_hi, en_rd, en_wr, en_dum, en_addr, en_cmd} <= reg_wdata[9:1];
            cmd_len <= reg_wdata[15:12];
            cmd_val <= reg_wdata[31:16];
          end
          2'd1: addr_q <= reg_wdata;
          2'd2: begin addr_len <= reg_wdata[5:0]; dum_len <= reg_wdata[13:8]; end
          default: begin wr_len <= reg_wdata[DLEN_W-1:0]; rd_len <= reg_wdata[16 +: DLEN_W]; end
        endcase
      end
      if (fin) start_q <= 1'b0;
      else if (reg_we && reg_sel == 2'd0 && reg_wdata[0]) start_q <= 1'b1;
    end
  end

  always_comb begin
    len_rd  = {18'd0, dum_len, 2'd0, addr_len};
    dlen_rd = '0;
    dlen_rd[DLEN_W-1:0]   = wr_len;
    dlen_rd[16 +: DLEN_W] = rd_len;
    case (reg_sel)
      2'd0: reg_rdata = {cmd_val, cmd_len, 2'd0, keep, didle, rd_hi, wr_hi,
                         en_rd, en_wr, en_dum, en_addr, en_cmd, start_q};
      2'd1: reg_rdata = addr_q;
      2'd2: reg_rdata = len_rd;
      default: reg_rdata = dlen_rd;
    endcase
  end

  function automatic st_t phase_of(input int r);
    case (r)
      0: return S_CMD;
      1: return S_ADDR;
      2: return S_DUMMY;
      3: return S_WR;
      default: return S_RD;
    endcase
  endfunction

  always_comb begin
    case (state)
      S_CMD:   from = 1;
      S_ADDR:  from = 2;
      S_DUMMY: from = 3;
      S_WR:    from = 4;
      default: from = 0;
    endcase
    nxt = S_DONE;
    for (int r = 4; r >= 0; r--)
      if (r >= from && en_vec[r]) nxt = phase_of(r);
  end

  always_comb begin
    case (state)
      S_CMD:   cur_len = DLEN_W'(cmd_len);
      S_ADDR:  cur_len = DLEN_W'(addr_len);
      S_DUMMY: cur_len = DLEN_W'(dum_len);
      S_WR:    cur_len = wr_len;
      default: cur_len = rd_len;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; prev_busy <= 1'b0;
    end else begin
      prev_busy <= (state != S_IDLE);
      if (sync_clr) begin
        state <= S_IDLE; cnt <= '0;
      end else begin
        case (state)
          S_IDLE:  if (start_q) state <= S_PREP;
          S_PREP:  if (sclk_en) begin state <= nxt; cnt <= '0; end
          S_RDEND: state <= S_DONE;
          S_DONE:  if (sclk_en) state <= S_IDLE;
          default: if (sclk_en) begin
            if (cnt == cur_len) begin
              cnt   <= '0;
              state <= (state == S_RD) ? S_RDEND : nxt;
            end else cnt <= cnt + 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_WORDS; i++) mem[i] <= '0;
    end else if (state == S_RD && sclk_en && !sync_clr) begin
      mem[widx][bidx] <= miso;
    end else if (buf_we) begin
      mem[buf_idx] <= buf_wdata;
    end
  end

  always_comb begin
    case (state)
      S_CMD:   mosi = cmd_val[ci];
      S_ADDR:  mosi = addr_q[ai[4:0]];
      S_WR:    mosi = mem[widx][bidx];
      default: mosi = 1'b0;
    endcase
  end

  assign buf_rdata = mem[buf_idx];
  assign sck_on    = shifting && !(state == S_DUMMY && didle);
  assign cs_n      = !(state != S_IDLE || keep);
  assign state_o   = state;
  assign end_o     = prev_busy && state == S_IDLE;

  p_clr_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> state == S_IDLE);
  p_start_prep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start_q && !sync_clr) |=> state == S_PREP);
  p_rdend_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RDEND && !sync_clr) |=> state == S_DONE);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_en && shifting && !sync_clr) |=> ($stable(state) && $stable(cnt)));
  p_start_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_q) |-> state == S_IDLE);
  p_end_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |=> !end_o);
endmodule

// File: tb/sim_sflash_seq.sv
`timescale 1ns/1ps
module sim_sflash_seq;
  logic        clk = 0, rst_n = 0, sync_clr = 0, sclk_en, reg_we = 0, buf_we = 0, miso = 0;
  logic [1:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, buf_wdata = 0, buf_rdata;
  logic [3:0]  buf_idx = 0, state_o;
  logic        cs_n, sck_on, mosi, end_o;

  int total = 0, fails = 0;
  int tick_div = 1, tph = 0;

  logic [63:0]  seqv;
  logic [15:0]  cmd_cap;
  logic [31:0]  addr_cap;
  logic [511:0] wr_bits, rd_pat;
  int           cyc [16], sckc [16];
  int           wk, rk, endc;
  logic         busy_bad, end_cs_bad;

  always #2.5 clk = ~clk;
  always @(negedge clk) tph <= (tph + 1 >= tick_div) ? 0 : tph + 1;
  assign sclk_en = (tph == 0);

  sflash_seq u0 (.clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .sclk_en(sclk_en),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .cs_n(cs_n), .sck_on(sck_on), .mosi(mosi), .miso(miso), .state_o(state_o), .end_o(end_o));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); reg_sel = sel; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0; reg_sel = 0;
  endtask

  task automatic rreg(input logic [1:0] sel, output logic [31:0] d);
    reg_sel = sel; #0.1; d = reg_rdata; reg_sel = 0; #0.1;
  endtask

  task automatic wbuf(input logic [3:0] i, input logic [31:0] d);
    @(negedge clk); buf_idx = i; buf_wdata = d; buf_we = 1;
    @(negedge clk); buf_we = 0;
  endtask

  task automatic rbuf(input logic [3:0] i, output logic [31:0] d);
    buf_idx = i; #0.1; d = buf_rdata;
  endtask

  task automatic run(input logic [31:0] ctrl, input logic exp_cs);
    logic [3:0] prevs;
    bit done;
    seqv = 0; prevs = 0; wk = 0; rk = 0; cmd_cap = 0; addr_cap = 0; wr_bits = 0;
    endc = 0; busy_bad = 0; end_cs_bad = 0; done = 0;
    for (int i = 0; i < 16; i++) begin cyc[i] = 0; sckc[i] = 0; end
    wreg(0, ctrl | 32'd1);
    for (int n = 0; n < 8000 && !done; n++) begin
      @(negedge clk);
      if (state_o != prevs) begin seqv = {seqv[59:0], state_o}; prevs = state_o; end
      cyc[state_o]++;
      if (sck_on) sckc[state_o]++;
      if (state_o != 0 && reg_rdata[0] !== 1'b1) busy_bad = 1;
      case (state_o)
        4'd2: cmd_cap = {cmd_cap[14:0], mosi};
        4'd3: addr_cap = {addr_cap[30:0], mosi};
        4'd6: begin wr_bits[wk] = mosi; wk++; end
        4'd5: begin miso = rd_pat[rk]; rk++; end
        default: ;
      endcase
      if (end_o) begin
        endc++; done = 1;
        if (cs_n !== exp_cs || reg_rdata[0] !== 1'b0) end_cs_bad = 1;
      end
    end
    @(negedge clk);
    if (end_o) endc++;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 state", state_o, 0);
    chk("R1 cs_n", cs_n, 1);
    rreg(0, d); chk("R1 ctrl", d, 32'h00007002);
    rreg(2, d); chk("R1 lengths", d, 32'h00000717);
    rreg(3, d); chk("R1 data lengths", d, 0);
  endtask

  task automatic t_cmd_only;
    run((32'h9F << 16) | (7 << 12) | 32'h2, 1'b1);
    chk("R2 cmd-only sequence", seqv, 64'h1270);
    chk("R4 cmd bits", cmd_cap[7:0], 8'h9F);
    chk("R3 cmd cycles", cyc[2], 8);
    chk("R7 busy while running", busy_bad, 0);
    chk("R9 end with cs released and start cleared", end_cs_bad, 0);
    chk("R9 single end pulse", endc, 1);
  endtask

  task automatic t_full;
    logic [31:0] d;
    wbuf(0, 32'hA5A50F0F); wbuf(1, 32'h0000C3C3);
    wreg(1, 32'h00123456);
    wreg(2, (3 << 8) | 23);
    wreg(3, (47 << 16) | 39);
    rd_pat = 0; rd_pat[47:0] = 48'h9ABCDEF01234;
    run((32'h0B << 16) | (7 << 12) | 32'h3E, 1'b1);
    chk("R2 full sequence", seqv, 64'h123465870);
    chk("R4 cmd bits", cmd_cap[7:0], 8'h0B);
    chk("R4 addr bits", addr_cap[23:0], 24'h123456);
    chk("R3 addr cycles", cyc[3], 24);
    chk("R3 dummy cycles", cyc[4], 4);
    chk("R3 write cycles", cyc[6], 40);
    chk("R3 read cycles", cyc[5], 48);
    chk("R8 dummy clock on", sckc[4], 4);
    chk("R8 clock in shift phases", sckc[2] + sckc[3] + sckc[5] + sckc[6], 120);
    chk("R5 write word0 bits", wr_bits[31:0], 32'hA5A50F0F);
    chk("R5 write word1 bits", wr_bits[39:32], 8'hC3);
    rbuf(0, d); chk("R5 read word0", d, 32'hDEF01234);
    rbuf(1, d); chk("R5 read word1", d, 32'h00009ABC);
  endtask

  task automatic t_upper;
    logic [31:0] d;
    wbuf(0, 32'h11111111); wbuf(8, 32'h13579BDF);
    wreg(3, (31 << 16) | 31);
    rd_pat = 0; rd_pat[31:0] = 32'hCAFEF00D;
    run((7 << 12) | 32'hF0, 1'b1);
    chk("R2 skip disabled phases", seqv, 64'h165870);
    chk("R6 write from word8", wr_bits[31:0], 32'h13579BDF);
    rbuf(8, d); chk("R6 read into word8", d, 32'hCAFEF00D);
    rbuf(0, d); chk("R6 word0 untouched", d, 32'h11111111);
  endtask

  task automatic t_dummy_idle;
    wreg(2, (7 << 8) | 23);
    run((32'h05 << 16) | (7 << 12) | 32'h10A, 1'b1);
    chk("R2 cmd+dummy sequence", seqv, 64'h12470);
    chk("R3 dummy cycles", cyc[4], 8);
    chk("R8 dummy clock held off", sckc[4], 0);
    chk("R8 cmd clock on", sckc[2], 8);
  endtask

  task automatic t_slow;
    tick_div = 3;
    run((32'h9F << 16) | (7 << 12) | 32'h2, 1'b1);
    chk("R3 cmd cycles at one-third rate", cyc[2], 24);
    chk("R3 slow sequence", seqv, 64'h1270);
    tick_div = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_keep;
    run((32'hABCD << 16) | (15 << 12) | 32'h202, 1'b0);
    chk("R4 16-bit cmd", cmd_cap, 16'hABCD);
    chk("R9 end pulse with keep", endc, 1);
    repeat (3) @(negedge clk);
    chk("R10 cs held in idle", cs_n, 0);
    chk("R10 state idle", state_o, 0);
    wreg(0, (7 << 12) | 32'h2);
    chk("R10 cs released after flag cleared", cs_n, 1);
  endtask

  task automatic t_sync;
    logic [31:0] d;
    wreg(3, 511);
    wreg(0, (7 << 12) | 32'h13);
    for (int n = 0; n < 100 && state_o != 4'd6; n++) @(negedge clk);
    chk("R11 reached write phase", state_o, 6);
    repeat (20) @(negedge clk);
    sync_clr = 1;
    @(negedge clk); sync_clr = 0;
    chk("R11 idle after clear", state_o, 0);
    chk("R11 cs released", cs_n, 1);
    chk("R9 end pulse on abort", end_o, 1);
    rreg(0, d); chk("R11 start cleared", d[0], 0);
    repeat (5) @(negedge clk);
    chk("R11 stays idle", state_o, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_cmd_only;
    t_full;
    t_upper;
    t_dummy_idle;
    t_slow;
    t_keep;
    t_sync;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule